// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a down-counting supervision timer that runs on the system clock. Software sets the start value, chooses what should happen on expiry, and then turns the counter on. From then on, software must keep servicing the timer. Each service restarts the count from the programmed value. If the count reaches zero first, the block raises the chosen response. The response is one of three: a reset request pulse, a nonmaskable interrupt level, or a general-purpose interrupt level.

A sticky flag records that the watchdog asked for a reset. Only a separate power-on reset input or a write-one-to-clear removes the flag, so ordinary system reset leaves it in place. Boot code can therefore read the flag and tell a watchdog reset from other resets.

The register port is a plain single-cycle write strobe with a combinational read. The port has four word locations: control, programmed value, live count and service.

Top module: `wdog_top`

## Requirements
- R1: After reset, control reads 3 (action "none", counter off, flag clear), and both the programmed value and the live count read all ones. Register locations are: control at address 0, programmed value at 1, live count at 2, service at 3.
- R2: Control bit 4 turns the counter on. The write that sets bit 4 while the counter is off loads the live count from the programmed value. After that, the count drops by one every clock. The action output rises one clock after the count has read zero.
- R3: Control bits [1:0] pick the action: 0 is reset request, 1 is nonmaskable interrupt, 2 is general interrupt, 3 is none. Only the selected output ever rises, and code 3 raises none.
- R4: Any write to the service location reloads the count from the programmed value. Timely servicing prevents expiry.
- R5: Both interrupt outputs are levels. Each stays high until a service write or until the counter is turned off, and then drops in the cycle after that write.
- R6: The reset request is one pulse, exactly RST_PULSE clocks wide, and fires once per expiry.
- R7: The flag sits at control bit 15. A reset-action expiry sets it. System reset leaves it unchanged. Power-on reset clears it, and so does writing 1 to bit 15.
- R8: A write to the programmed value while the counter runs leaves the live count alone until the next reload. While the counter is off, such a write also sets the live count.
- R9: While the counter is off, the live count holds its value and all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset; the only reset that clears the flag |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 2 | Register location |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr` (combinational) |
| rst_req | output | 1 | Reset request pulse |
| nmi | output | 1 | Nonmaskable interrupt level |
| irq | output | 1 | General interrupt level |

## Verification
A wrong count shows up in the live count register at once. It also shows up as an action edge one or more cycles off from "programmed value plus one" clocks after the counter is turned on. The bench therefore sweeps every action code against a range of small start values and samples each cycle around the expected expiry. A broken flag or pulse counter shows up in the pulse width, and shows up when control is read back after a system reset, a power-on reset or a clearing write.

// File: rtl/wdog_pkg.sv
// Shared definitions for the watchdog: action codes, register locations and
// control bit positions. Assumes the data width is at least 16 bits.
package wdog_pkg;
    typedef enum logic [1:0] {
        ACT_RESET = 2'd0,
        ACT_NMI   = 2'd1,
        ACT_IRQ   = 2'd2,
        ACT_NONE  = 2'd3
    } wd_action_e;

    localparam logic [1:0] LOC_CTRL = 2'd0;
    localparam logic [1:0] LOC_LOAD = 2'd1;
    localparam logic [1:0] LOC_CNT  = 2'd2;
    localparam logic [1:0] LOC_SVC  = 2'd3;

    localparam int unsigned EN_BIT   = 4;
    localparam int unsigned FLAG_BIT = 15;
endpackage

// File: rtl/wdog_regs.sv
// Register file: control, programmed value and the sticky flag, plus read mux.
// Produces restart (service or turn-on) and preset (value write while off).
// Assumes CNT_W >= 16 so the flag bit fits.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             flag_set,
    output logic             en,
    output wd_action_e       act,
    output logic [CNT_W-1:0] load_q,
    output logic             restart,
    output logic             preset,
    output logic [CNT_W-1:0] rdata
);
    logic flag_q;
    logic ctrl_wr;

    assign ctrl_wr = wr_en && (addr == LOC_CTRL);
    assign restart = wr_en && ((addr == LOC_SVC) || (ctrl_wr && wdata[EN_BIT] && !en));
    assign preset  = wr_en && (addr == LOC_LOAD) && !en;

    // Control fields, reset by system reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            act <= ACT_NONE;
        end else if (ctrl_wr) begin
            en  <= wdata[EN_BIT];
            act <= wd_action_e'(wdata[1:0]);
        end
    end

    // Programmed start value
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_q <= '1;
        else if (wr_en && addr == LOC_LOAD)
            load_q <= wdata;
    end

    // Sticky flag: set by reset-action expiry, cleared by power-on or write-one
    always_ff @(posedge clk) begin
        if (!por_n)
            flag_q <= 1'b0;
        else if (flag_set)
            flag_q <= 1'b1;
        else if (ctrl_wr && wdata[FLAG_BIT])
            flag_q <= 1'b0;
    end

    // Read mux
    always_comb begin
        rdata = '0;
        case (addr)
            LOC_CTRL: begin
                rdata[1:0]      = act;
                rdata[EN_BIT]   = en;
                rdata[FLAG_BIT] = flag_q;
            end
            LOC_LOAD: rdata = load_q;
            LOC_CNT:  rdata = cnt;
            default:  rdata = '0;
        endcase
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!por_n)
        flag_set |=> flag_q); // R7
    AST_FLAG_SURVIVES: assert property (@(posedge clk) disable iff (!por_n)
        (flag_q && !(ctrl_wr && wdata[FLAG_BIT])) |=> flag_q); // R7
endmodule

// File: rtl/wdog_counter.sv
// Down counter with expiry latch. Counts only while enabled, holds otherwise.
// expired stays set until a restart or until the counter is turned off.
module wdog_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             preset,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] preset_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expired,
    output logic             expire_hit
);
    assign expire_hit = en && (cnt == '0) && !expired && !restart;

    // Count register: reload, preset, or step down
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '1;
        else if (restart)
            cnt <= load_val;
        else if (preset)
            cnt <= preset_val;
        else if (en && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Expiry latch
    always_ff @(posedge clk) begin
        if (!rst_n)
            expired <= 1'b0;
        else if (!en || restart)
            expired <= 1'b0;
        else if (expire_hit)
            expired <= 1'b1;
    end

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart && !preset) |=> $stable(cnt)); // R9
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt != '0 && !restart) |=> (cnt == $past(cnt) - 1'b1)); // R2
    AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> ($past(cnt) == '0)); // R2
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == $past(load_val))); // R4
endmodule

// File: rtl/wdog_action.sv
// Expiry response: one reset pulse of RST_PULSE clocks, or an interrupt level.
// Assumes RST_PULSE >= 2.
module wdog_action
    import wdog_pkg::*;
#(
    parameter int unsigned RST_PULSE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  wd_action_e act,
    input  logic       expired,
    input  logic       expire_hit,
    output logic       rst_req,
    output logic       nmi,
    output logic       irq,
    output logic       flag_set
);
    localparam int unsigned PW = $clog2(RST_PULSE + 1);
    localparam logic [PW-1:0] PULSE_LEN = PW'(RST_PULSE);

    logic [PW-1:0] pulse_q;

    // Reset pulse width counter, started once per expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= '0;
        else if (expire_hit && act == ACT_RESET)
            pulse_q <= PULSE_LEN;
        else if (pulse_q != '0)
            pulse_q <= pulse_q - 1'b1;
    end

    assign rst_req  = (pulse_q != '0);
    assign nmi      = en && expired && (act == ACT_NMI);
    assign irq      = en && expired && (act == ACT_IRQ);
    assign flag_set = expire_hit && (act == ACT_RESET);

    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |=> rst_req); // R6
    AST_RST_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(expire_hit)); // R6
endmodule

// File: rtl/wdog_top.sv
// Watchdog top: wires registers, counter and action stage together.
// rst_n resets everything except the sticky flag, which only por_n clears.
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned RST_PULSE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             rst_req,
    output logic             nmi,
    output logic             irq
);
    logic             en, restart, preset, expired, expire_hit, flag_set;
    wd_action_e       act;
    logic [CNT_W-1:0] load_q, cnt;

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .cnt(cnt), .flag_set(flag_set), .en(en), .act(act),
        .load_q(load_q), .restart(restart), .preset(preset), .rdata(rdata)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .preset(preset),
        .load_val(load_q), .preset_val(wdata), .cnt(cnt), .expired(expired),
        .expire_hit(expire_hit)
    );

    wdog_action #(.RST_PULSE(RST_PULSE)) u_act (
        .clk(clk), .rst_n(rst_n), .en(en), .act(act), .expired(expired),
        .expire_hit(expire_hit), .rst_req(rst_req), .nmi(nmi), .irq(irq),
        .flag_set(flag_set)
    );
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
    localparam int CNT_W = 32;
    localparam int RSTP  = 4;

    logic clk = 1'b0;
    logic rst_n, por_n, wr_en;
    logic [1:0] addr;
    logic [CNT_W-1:0] wdata, rdata;
    logic rst_req, nmi, irq;
    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wdog_top #(.CNT_W(CNT_W), .RST_PULSE(RSTP)) dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .nmi(nmi), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    function automatic logic [2:0] outv_for(input int act);
        case (act)
            0: return 3'b100;
            1: return 3'b010;
            2: return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run hung, got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 0; por_n = 0; wr_en = 0; addr = 0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 32'h3);
        rd(2'd1, v); chk("R1 load", v, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R1 count", v, 32'hFFFF_FFFF);
        chk("R1 outputs", {rst_req, nmi, irq}, 3'b000);

        // R2 R3 R5 R6 R7 sweep over action codes and start values
        for (int a = 0; a < 4; a++) begin
            for (int L = 0; L < 5; L++) begin
                wr(2'd1, L);
                wr(2'd0, a);
                wr(2'd0, 32'h10 | a);
                rd(2'd2, v); chk("R2 start value", v, L);
                for (int k = 0; k <= L; k++) begin
                    chk("R2 no early action", {rst_req, nmi, irq}, 3'b000);
                    @(negedge clk);
                end
                if (a == 0) begin
                    for (int p = 0; p < RSTP; p++) begin
                        chk("R6 pulse high", {rst_req, nmi, irq}, 3'b100);
                        @(negedge clk);
                    end
                    for (int p = 0; p < 3; p++) begin
                        chk("R6 single pulse", {rst_req, nmi, irq}, 3'b000);
                        @(negedge clk);
                    end
                    rd(2'd0, v); chk("R7 flag set", v[15], 1'b1);
                    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
                    rd(2'd0, v); chk("R7 flag survives system reset", v, 32'h8003);
                    if (L == 4) begin
                        por_n = 0; @(negedge clk); por_n = 1;
                        rd(2'd0, v); chk("R7 power-on clears flag", v, 32'h3);
                    end else begin
                        wr(2'd0, 32'h8003);
                        rd(2'd0, v); chk("R7 write-one clears flag", v, 32'h3);
                    end
                end else begin
                    for (int p = 0; p < 3; p++) begin
                        chk("R3 R5 selected level", {rst_req, nmi, irq}, outv_for(a));
                        @(negedge clk);
                    end
                    wr(2'd0, a);
                    chk("R5 R9 off clears level", {rst_req, nmi, irq}, 3'b000);
                end
            end
        end

        // R4 R5 servicing
        wr(2'd1, 6);
        wr(2'd0, 32'h11);
        for (int s = 0; s < 5; s++) begin
            for (int k = 0; k < 4; k++) begin
                chk("R4 serviced, no expiry", {rst_req, nmi, irq}, 3'b000);
                @(negedge clk);
            end
            wr(2'd3, 0);
        end
        for (int k = 0; k <= 6; k++) begin
            chk("R4 no early action after service", {rst_req, nmi, irq}, 3'b000);
            @(negedge clk);
        end
        chk("R4 expiry after last service", {rst_req, nmi, irq}, 3'b010);
        wr(2'd3, 0);
        chk("R5 service drops level", {rst_req, nmi, irq}, 3'b000);
        rd(2'd2, v); chk("R4 reload value", v, 6);
        wr(2'd0, 32'h1);

        // R8 value write while running, R9 hold when off
        wr(2'd1, 20);
        wr(2'd0, 32'h13);
        rd(2'd2, v); chk("R8 start", v, 20);
        wr(2'd1, 3);
        rd(2'd2, v); chk("R8 running count unaffected", v, 19);
        rd(2'd1, v); chk("R8 new value stored", v, 3);
        wr(2'd3, 0);
        rd(2'd2, v); chk("R8 takes effect on reload", v, 3);
        wr(2'd0, 32'h3);
        rd(2'd2, v); chk("R9 count after turn-off", v, 2);
        repeat (5) @(negedge clk);
        rd(2'd2, v); chk("R9 count holds", v, 2);
        chk("R9 no outputs", {rst_req, nmi, irq}, 3'b000);
        wr(2'd1, 9);
        rd(2'd2, v); chk("R8 preset while off", v, 9);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule